// File: doc/BRIEF.md
# Character Display Host Register Interface

This block is the microcontroller side of a character display controller. Each host request carries a select bit and a direction bit. Together they choose one of four operations: write an instruction, read status, write data, or read data. The block keeps an address counter that points into either the display memory or the pattern memory. A data write is stored at the counter's location. Data for the host is fetched ahead of time into a data register, so a data read answers from that register at once and then starts the fetch for the next location.

Writing an instruction or data starts a busy period of `BUSY_CYC` clock cycles, counted by a down-counter. Any write that arrives during a busy period is dropped. A status read returns the busy flag and an address. While busy, that address is the counter value from before the running operation began. Memory accesses use their own internal strobes and never the host handshake.

Requests and responses use valid/ready. A request transfers in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a fetch is in progress and while a read response has not been taken. A response stays valid, with its data unchanged, until `rsp_ready` is high.

Top module: `dispif_host`

## Requirements
- R1: After reset the address counter, the space select and the data register are all zero, the busy flag is clear and no response is pending. A status read returns 0x00 and a data read returns 0x00.
- R2: An instruction byte with bit 7 set loads bits 6..0 into the counter and selects display memory. Bits 7..6 equal to 01 load bits 5..0 and select pattern memory. Either form starts a prefetch. The two memories hold separate contents.
- R3: A data write stores the byte at the counter in the selected memory, then increments the counter. In display memory the counter wraps from 0x7F to 0x00. In pattern memory it wraps from 0x3F to 0x00, and bit 6 stays 0.
- R4: After an address-set instruction, the next data read returns the byte stored at that address.
- R5: A data read returns the data register, increments the counter as in R3, and prefetches the new location. Consecutive reads therefore return consecutive bytes.
- R6: An accepted, non-ignored instruction or data write sets the busy flag (status bit 7). A status read accepted 1 to `BUSY_CYC` cycles after that write sees busy=1. One accepted `BUSY_CYC`+1 cycles after sees busy=0, and a write accepted then takes effect.
- R7: An instruction or data write accepted while busy changes neither the counter, nor the space, nor memory.
- R8: A status read returns {busy, address} on bits 7 and 6..0. While busy, the address is the counter value from before the running write. When idle, it is the current counter.
- R9: `req_ready` is low while a response is pending or a fetch runs. A response stays valid and stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_sel | input | 1 | 0 = instruction/status, 1 = data |
| req_rw | input | 1 | 0 = write, 1 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |

## Verification
The busy timer can run out in the same cycle that a new request arrives. The bench provokes this by issuing a status read or a write exactly `BUSY_CYC` and `BUSY_CYC`+1 cycles after a write, counted from the accept edge. It judges the outcome from the busy bit and the address that later status reads return: one cycle earlier the write must be dropped, one cycle later it must take effect. An address-set followed at once by a status read checks that the reported address is the value from before the set.

// File: rtl/dispif_pkg.sv
package dispif_pkg;
  typedef enum logic [1:0] {
    OP_INSTR = 2'b00,
    OP_STAT  = 2'b01,
    OP_WDATA = 2'b10,
    OP_RDATA = 2'b11
  } host_op_e;

  typedef enum logic {
    SPC_DISP = 1'b0,
    SPC_PAT  = 1'b1
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2
  } seq_e;
endpackage

// File: rtl/dispif_busy.sv
module dispif_busy #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= CW'(CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dispif_ram.sv
module dispif_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dispif_ctrl.sv
module dispif_ctrl
  import dispif_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PAT_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_sel,
  input  logic                req_rw,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_data,
  input  logic                busy,
  output logic                busy_load,
  output logic                mem_we,
  output logic                mem_re,
  output logic [DW-2:0]       mem_addr,
  output space_e              mem_space,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata
);
  localparam int AC_W = DW - 1;

  logic [AC_W-1:0]   ac_q, snap_q, ac_inc;
  logic [PAT_AW-1:0] pat_inc;
  logic [DW-1:0]     dr_q, rsp_q;
  logic              rsp_v_q;
  space_e            spc_q;
  seq_e              st_q;
  host_op_e          op;
  logic              fire, set_disp, set_pat;

  assign op        = host_op_e'({req_sel, req_rw});
  assign req_ready = (st_q == ST_IDLE) && !rsp_v_q;
  assign fire      = req_valid && req_ready;
  assign set_disp  = req_wdata[DW-1];
  assign set_pat   = !req_wdata[DW-1] && req_wdata[DW-2];

  assign busy_load = fire && !busy && (op == OP_INSTR || op == OP_WDATA);
  assign mem_we    = fire && !busy && (op == OP_WDATA);
  assign mem_re    = (st_q == ST_FETCH);
  assign mem_addr  = ac_q;
  assign mem_space = spc_q;
  assign mem_wdata = req_wdata;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;

  assign pat_inc = ac_q[PAT_AW-1:0] + 1'b1;
  assign ac_inc  = (spc_q == SPC_PAT) ? {{(AC_W-PAT_AW){1'b0}}, pat_inc}
                                      : ac_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q    <= '0;
      snap_q  <= '0;
      dr_q    <= '0;
      rsp_q   <= '0;
      rsp_v_q <= 1'b0;
      spc_q   <= SPC_DISP;
      st_q    <= ST_IDLE;
    end else begin
      if (rsp_v_q && rsp_ready) rsp_v_q <= 1'b0;
      case (st_q)
        ST_FETCH: st_q <= ST_LOAD;
        ST_LOAD: begin
          dr_q <= mem_rdata;
          st_q <= ST_IDLE;
        end
        default: begin
          if (fire) begin
            case (op)
              OP_INSTR: if (!busy) begin
                snap_q <= ac_q;
                if (set_disp) begin
                  ac_q  <= req_wdata[AC_W-1:0];
                  spc_q <= SPC_DISP;
                  st_q  <= ST_FETCH;
                end else if (set_pat) begin
                  ac_q  <= {{(AC_W-PAT_AW){1'b0}}, req_wdata[PAT_AW-1:0]};
                  spc_q <= SPC_PAT;
                  st_q  <= ST_FETCH;
                end
              end
              OP_STAT: begin
                rsp_q   <= {busy, busy ? snap_q : ac_q};
                rsp_v_q <= 1'b1;
              end
              OP_WDATA: if (!busy) begin
                snap_q <= ac_q;
                ac_q   <= ac_inc;
                st_q   <= ST_FETCH;
              end
              default: begin
                rsp_q   <= dr_q;
                rsp_v_q <= 1'b1;
                ac_q    <= ac_inc;
                st_q    <= ST_FETCH;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dispif_host.sv
module dispif_host
  import dispif_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAT_AW   = 6,
  parameter int BUSY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel,
  input  logic              req_rw,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int AC_W = DATA_W - 1;

  logic              busy, busy_load, mem_we, mem_re;
  logic [AC_W-1:0]   ac;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, disp_rd, pat_rd;
  space_e            mem_space;

  dispif_ctrl #(.DW(DATA_W), .PAT_AW(PAT_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_rw(req_rw), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .busy_load(busy_load),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(ac),
    .mem_space(mem_space), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  dispif_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(busy_load), .busy(busy)
  );

  dispif_ram #(.AW(AC_W), .DW(DATA_W)) u_disp_ram (
    .clk(clk),
    .we(mem_we && mem_space == SPC_DISP),
    .re(mem_re && mem_space == SPC_DISP),
    .addr(ac), .wdata(mem_wdata), .rdata(disp_rd)
  );

  dispif_ram #(.AW(PAT_AW), .DW(DATA_W)) u_pat_ram (
    .clk(clk),
    .we(mem_we && mem_space == SPC_PAT),
    .re(mem_re && mem_space == SPC_PAT),
    .addr(ac[PAT_AW-1:0]), .wdata(mem_wdata), .rdata(pat_rd)
  );

  assign mem_rdata = (mem_space == SPC_PAT) ? pat_rd : disp_rd;
endmodule

// File: rtl/dispif_host_chk.sv
module dispif_host_chk
  import dispif_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PAT_AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_sel,
  input logic          req_rw,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          busy,
  input logic [DW-2:0] ac,
  input space_e        mem_space,
  input logic          mem_we,
  input logic          mem_re
);
  localparam int AC_W = DW - 1;
  logic fire;
  assign fire = req_valid && req_ready;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9
  AST_NO_REQ_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && busy && !req_sel && !req_rw |=> $stable(ac)); // R7
  AST_PAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_space == SPC_PAT |-> ac[AC_W-1:PAT_AW] == '0); // R3
  AST_SET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !busy && !req_sel && !req_rw && req_wdata[DW-1]
    |=> mem_re && ac == $past(req_wdata[AC_W-1:0])); // R4
  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !busy && !req_rw |=> busy); // R6
  AST_STAT_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_sel && req_rw |=> rsp_valid && rsp_data[DW-1] == $past(busy)); // R8
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R3
endmodule

bind dispif_host dispif_host_chk #(.DW(DATA_W), .PAT_AW(PAT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_sel(req_sel), .req_rw(req_rw), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .busy(busy), .ac(ac), .mem_space(mem_space),
  .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/dispif_host_bench.sv
`timescale 1ns/1ps
module dispif_host_bench;
  localparam int BUSY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_sel = 1'b0, req_rw = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_ready = 1'b1;
  logic       req_ready, rsp_valid;
  logic [7:0] rsp_data;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #5 clk = ~clk;

  dispif_host #(.BUSY_CYC(BUSY)) u_dispif_host (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_rw(req_rw), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as responses complete
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected response", rsp_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data === e, t, rsp_data, e);
      end
    end
  end

  task automatic issue(input logic sel, input logic rw, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_rw = rw; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic status(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    issue(1'b0, 1'b1, 8'h00);
  endtask
  task automatic rdata(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    issue(1'b1, 1'b1, 8'h00);
  endtask
  task automatic winst(input logic [7:0] d); issue(1'b0, 1'b0, d); endtask
  task automatic wdata(input logic [7:0] d); issue(1'b1, 1'b0, d); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic settle; idle(BUSY + 4); endtask

  initial begin
    #500000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    status(8'h00, "R1 reset status");
    rdata(8'h00, "R1 reset data register");
    settle;

    winst(8'h90); settle;
    wdata(8'hA1); settle;
    wdata(8'hB2); settle;
    wdata(8'hC3); settle;
    status(8'h13, "R3 counter after three writes");

    winst(8'h90); settle;
    rdata(8'hA1, "R4 read after address set");
    rdata(8'hB2, "R5 second sequential read");
    rdata(8'hC3, "R5 third sequential read");
    status(8'h13, "R5 counter after reads");

    winst(8'hFF); settle;
    wdata(8'h5A); settle;
    status(8'h00, "R3 display wrap");
    winst(8'hFF); settle;
    rdata(8'h5A, "R4 read at top address");
    settle;

    winst(8'h7F); settle;
    wdata(8'h11); settle;
    status(8'h00, "R3 pattern wrap");
    winst(8'h7F); settle;
    rdata(8'h11, "R2 pattern memory read");
    status(8'h00, "R3 pattern counter after read");
    winst(8'hFF); settle;
    rdata(8'h5A, "R2 display memory separate");
    settle;

    winst(8'h85); settle;
    winst(8'h01);
    idle(BUSY - 1);
    status(8'h85, "R6 busy at last busy cycle");
    settle;
    winst(8'h01);
    idle(BUSY);
    status(8'h05, "R6 idle right after busy period");
    settle;

    winst(8'hA0);
    status(8'h85, "R8 status shows pre-set address while busy");
    settle;
    status(8'h20, "R8 status shows new address when idle");

    winst(8'hB0); settle;
    wdata(8'h77); settle;
    winst(8'hB0);
    wdata(8'hEE);
    winst(8'h85);
    settle;
    status(8'h30, "R7 counter unchanged by busy writes");
    rdata(8'h77, "R7 memory unchanged by busy write");
    settle;

    winst(8'h01);
    idle(BUSY);
    winst(8'h88); settle;
    status(8'h08, "R6 write accepted after busy ends");
    winst(8'h01);
    idle(BUSY - 1);
    winst(8'h8C); settle;
    status(8'h08, "R7 write at last busy cycle dropped");
    settle;

    rsp_ready = 1'b0;
    status(8'h08, "R9 held response");
    idle(3);
    check(rsp_valid == 1'b1, "R9 response held valid", rsp_valid, 1);
    check(req_ready == 1'b0, "R9 no request while response pending", req_ready, 0);
    check(rsp_data == 8'h08, "R9 response data stable", rsp_data, 8'h08);
    rsp_ready = 1'b1;
    idle(10);
    check(exp_q.size() == 0, "R9 all responses delivered", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule